// File: doc/BRIEF.md
# Timer Channel Status Flags

This block is one 16-bit timer channel. A counter runs up or down under control inputs. Two general registers, A and B, sit beside it. Each one works either as a compare register, which flags when the counter equals it, or as a capture register, which takes a snapshot of the counter on a rising edge of its own capture input. A third flag records counter wrap-around in either direction.

The three flags are sticky. Software reads them through an 8-bit status register on a simple register bus. Clearing is a two-step handshake. A read must first return the flag as 1, which arms that flag. A later write of 0 to that bit then clears it. The same bus loads the counter and, while in compare mode, the general registers, one byte at a time.

Bus address map (3-bit address):

| Address | Register |
|---|---|
| 0 | status |
| 1 | reserved, reads 0x00 |
| 2 | counter low byte |
| 3 | counter high byte |
| 4 | general register A low byte |
| 5 | general register A high byte |
| 6 | general register B low byte |
| 7 | general register B high byte |

Top module: `tmr_chan_top`

## Requirements
- R1: Reading address 0 returns the status register. Bit 0 is the A flag, bit 1 is the B flag and bit 2 is the wrap flag. Bits 7..3 always read as 1. Address 1 reads 0x00. Read data is combinational from the current state.
- R2: After a synchronous reset, all flags, arm bits, the counter and both general registers are 0, so the status register reads 0xF8.
- R3: While enabled and counting up with no counter load in that cycle, a step from 0xFFFF to 0x0000 sets the wrap flag at that same clock edge.
- R4: While enabled and counting down with no counter load in that cycle, a step from 0x0000 to 0xFFFF sets the wrap flag at that same clock edge.
- R5: A general register in compare mode (mode input 0) sets its flag at the edge that ends a cycle in which the counter equals that register.
- R6: A general register in capture mode (mode input 1) copies the counter and sets its flag two edges after its capture input is first sampled high. The capture input passes through two synchroniser stages and then a rising-edge detector. The value copied is the counter value present before that capturing edge.
- R7: A status write with a 1 in a flag bit leaves that flag and its arm bit unchanged. Writes to bits 7..3 have no effect.
- R8: A status write of 0 to a flag that has not been read as 1 since its last clear has no effect.
- R9: A status read that returns a flag as 1 arms that flag. A later write of 0 to that bit clears the flag and also disarms it, so a further clear needs a fresh read of 1.
- R10: If a set condition and a valid clearing write hit the same flag in one cycle, the flag stays 1 and the arm bit is still used up.
- R11: A general register in capture mode ignores bus writes. In compare mode, writes to addresses 4..7 load the addressed byte.
- R12: The counter holds when the enable input is low. Bus writes to addresses 2 and 3 load the addressed counter byte. A load takes priority over counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter enable |
| cnt_down | input | 1 | 1 = count down, 0 = count up |
| mode_a | input | 1 | Register A role: 0 compare, 1 capture |
| mode_b | input | 1 | Register B role: 0 compare, 1 capture |
| cap_a | input | 1 | Asynchronous capture input for register A |
| cap_b | input | 1 | Asynchronous capture input for register B |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; arms flags read as 1 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |

## Verification
The in-RTL assertions check these on every cycle:
- A raised set condition always leaves its flag at 1, even against a clearing write.
- A flag without an arm bit never drops.
- A held counter stays put.
- A capture edge stores the previous counter value.
- A register in capture mode ignores bus writes.
- The unused status bits read as ones.

The handshake ordering can only be shown by the bench's scenarios: arming on a read, using up the arm, and ignored one-writes and unarmed zero-writes. The same holds for wrap-around in both directions, compare timing, and synchroniser latency. A cycle-level reference model compares the read data against the design on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W = 16;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int NFLAG = 3;
    localparam int SYNC_STAGES = 2;

    localparam int F_GA  = 0;
    localparam int F_GB  = 1;
    localparam int F_WRP = 2;

    localparam logic [AW-1:0] ADR_STAT = 3'd0;
    localparam logic [AW-1:0] ADR_RSVD = 3'd1;
    localparam logic [AW-1:0] ADR_CNTL = 3'd2;
    localparam logic [AW-1:0] ADR_CNTH = 3'd3;
    localparam logic [AW-1:0] ADR_GRAL = 3'd4;
    localparam logic [AW-1:0] ADR_GRAH = 3'd5;
    localparam logic [AW-1:0] ADR_GRBL = 3'd6;
    localparam logic [AW-1:0] ADR_GRBH = 3'd7;

    localparam logic GR_CMP = 1'b0;
    localparam logic GR_CAP = 1'b1;

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } bus_req_t;

    function automatic logic [CNT_W-1:0] put_byte(input logic [CNT_W-1:0] v,
                                                  input logic hi,
                                                  input logic [DW-1:0] b);
        return hi ? {b, v[DW-1:0]} : {v[CNT_W-1:DW], b};
    endfunction

    function automatic logic [DW-1:0] get_byte(input logic [CNT_W-1:0] v,
                                               input logic hi);
        return hi ? v[CNT_W-1:DW] : v[DW-1:0];
    endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             down,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [DW-1:0]    wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] BOT = '0;

    logic loading;
    assign loading = ld_lo | ld_hi;
    assign wrap    = en && !loading && (down ? (cnt == BOT) : (cnt == TOP));

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (ld_lo) cnt <= put_byte(cnt, 1'b0, wdata);
        else if (ld_hi) cnt <= put_byte(cnt, 1'b1, wdata);
        else if (en)    cnt <= down ? cnt - 1'b1 : cnt + 1'b1;
    end

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!en && !loading) |=> $stable(cnt));
    p_wrap_up_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !loading && !down && cnt == TOP) |=> cnt == BOT);
    p_wrap_dn_r4: assert property (@(posedge clk) disable iff (rst)
        (en && !loading && down && cnt == BOT) |=> cnt == TOP);
endmodule

// File: rtl/tmr_genreg.sv
module tmr_genreg
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode,
    input  logic             cap_in,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [DW-1:0]    wdata,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] gr,
    output logic             hit
);
    logic [SYNC_STAGES:0] sh;
    logic                 rise;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SYNC_STAGES-1:0], cap_in};
    end

    assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
    assign hit  = (mode == GR_CAP) ? rise : (cnt == gr);

    always_ff @(posedge clk) begin
        if (rst) gr <= '0;
        else if (mode == GR_CAP) begin
            if (rise) gr <= cnt;
        end else if (wr_lo) gr <= put_byte(gr, 1'b0, wdata);
        else if (wr_hi)     gr <= put_byte(gr, 1'b1, wdata);
    end

    p_capture_load_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == GR_CAP && rise) |=> gr == $past(cnt));
    p_cap_write_block_r11: assert property (@(posedge clk) disable iff (rst)
        (mode == GR_CAP && !rise) |=> $stable(gr));
endmodule

// File: rtl/tmr_status.sv
module tmr_status
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] set,
    input  logic             rd_stat,
    input  logic             wr_stat,
    input  logic [NFLAG-1:0] wbits,
    output logic [NFLAG-1:0] flags
);
    logic [NFLAG-1:0] arm_q;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        logic clr;
        assign clr = wr_stat && !wbits[i] && arm_q[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
                arm_q[i] <= 1'b0;
            end else begin
                if (set[i])   flags[i] <= 1'b1;
                else if (clr) flags[i] <= 1'b0;

                if (clr)                       arm_q[i] <= 1'b0;
                else if (rd_stat && flags[i])  arm_q[i] <= 1'b1;
            end
        end

        p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> flags[i]);
        p_noarm_hold_r8: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !arm_q[i]) |=> flags[i]);
        p_arm_used_r9: assert property (@(posedge clk) disable iff (rst)
            (wr_stat && !wbits[i] && arm_q[i]) |=> !arm_q[i]);
    end
endmodule

// File: rtl/tmr_chan_top.sv
module tmr_chan_top
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_en,
    input  logic          cnt_down,
    input  logic          mode_a,
    input  logic          mode_b,
    input  logic          cap_a,
    input  logic          cap_b,
    input  logic [2:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata
);
    bus_req_t         req;
    logic [CNT_W-1:0] cnt, gra, grb;
    logic             wrap, hit_a, hit_b;
    logic [NFLAG-1:0] flags, set;

    assign req = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, data: bus_wdata};

    tmr_counter u_cnt (
        .clk(clk), .rst(rst), .en(cnt_en), .down(cnt_down),
        .ld_lo(req.wr && req.addr == ADR_CNTL),
        .ld_hi(req.wr && req.addr == ADR_CNTH),
        .wdata(req.data), .cnt(cnt), .wrap(wrap)
    );

    tmr_genreg u_gra (
        .clk(clk), .rst(rst), .mode(mode_a), .cap_in(cap_a),
        .wr_lo(req.wr && req.addr == ADR_GRAL),
        .wr_hi(req.wr && req.addr == ADR_GRAH),
        .wdata(req.data), .cnt(cnt), .gr(gra), .hit(hit_a)
    );

    tmr_genreg u_grb (
        .clk(clk), .rst(rst), .mode(mode_b), .cap_in(cap_b),
        .wr_lo(req.wr && req.addr == ADR_GRBL),
        .wr_hi(req.wr && req.addr == ADR_GRBH),
        .wdata(req.data), .cnt(cnt), .gr(grb), .hit(hit_b)
    );

    always_comb begin
        set        = '0;
        set[F_GA]  = hit_a;
        set[F_GB]  = hit_b;
        set[F_WRP] = wrap;
    end

    tmr_status u_stat (
        .clk(clk), .rst(rst), .set(set),
        .rd_stat(req.rd && req.addr == ADR_STAT),
        .wr_stat(req.wr && req.addr == ADR_STAT),
        .wbits(req.data[NFLAG-1:0]), .flags(flags)
    );

    always_comb begin
        case (req.addr)
            ADR_STAT: bus_rdata = {{(DW-NFLAG){1'b1}}, flags};
            ADR_RSVD: bus_rdata = '0;
            ADR_CNTL: bus_rdata = get_byte(cnt, 1'b0);
            ADR_CNTH: bus_rdata = get_byte(cnt, 1'b1);
            ADR_GRAL: bus_rdata = get_byte(gra, 1'b0);
            ADR_GRAH: bus_rdata = get_byte(gra, 1'b1);
            ADR_GRBL: bus_rdata = get_byte(grb, 1'b0);
            default:  bus_rdata = get_byte(grb, 1'b1);
        endcase
    end

    p_unused_ones_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADR_STAT) |-> bus_rdata[7:3] == 5'h1F);
    p_set_b_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_b == GR_CMP && cnt == grb) |=> bus_addr != ADR_STAT || bus_rdata[F_GB]);
endmodule

// File: tb/sim_tmr_chan_top.sv
module sim_tmr_chan_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic cnt_en = 0, cnt_down = 0, mode_a = 1, mode_b = 1, cap_a = 0, cap_b = 0;
    logic [2:0] bus_addr = 0;
    logic bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] saved;

    // behavioural reference state
    int unsigned m_cnt, m_gra, m_grb;
    bit m_f[3], m_arm[3];
    bit ma[3], mb[3];

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_chan_top u0 (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_down(cnt_down),
        .mode_a(mode_a), .mode_b(mode_b), .cap_a(cap_a), .cap_b(cap_b),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            0: return {5'h1F, m_f[2], m_f[1], m_f[0]};
            1: return 8'h00;
            2: return m_cnt[7:0];
            3: return m_cnt[15:8];
            4: return m_gra[7:0];
            5: return m_gra[15:8];
            6: return m_grb[7:0];
            default: return m_grb[15:8];
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%02h expected=%02h", tag, $time, act, exp);
        end
    endtask

    // every clock: compare then advance model (R1 readback of all registers)
    always @(posedge clk) begin
        if (!rst) chk("R1 per-cycle readback", bus_rdata, m_read(bus_addr));
        if (rst) begin
            m_cnt = 0; m_gra = 0; m_grb = 0;
            for (int i = 0; i < 3; i++) begin m_f[i] = 0; m_arm[i] = 0; ma[i] = 0; mb[i] = 0; end
        end else begin
            bit ld, wrp, ra, rb, ha, hb, sw, sr, clr;
            bit s[3];
            int unsigned c0;
            c0  = m_cnt;
            ld  = bus_wr && (bus_addr == 2 || bus_addr == 3);
            wrp = cnt_en && !ld && (cnt_down ? (c0 == 0) : (c0 == 16'hFFFF));
            ra  = ma[1] && !ma[2];
            rb  = mb[1] && !mb[2];
            ha  = mode_a ? ra : (c0 == m_gra);
            hb  = mode_b ? rb : (c0 == m_grb);
            s[0] = ha; s[1] = hb; s[2] = wrp;
            sw = bus_wr && bus_addr == 0;
            sr = bus_rd && bus_addr == 0;
            for (int i = 0; i < 3; i++) begin
                clr = sw && !bus_wdata[i] && m_arm[i];
                if (clr) m_arm[i] = 0; else if (sr && m_f[i]) m_arm[i] = 1;
                if (s[i]) m_f[i] = 1; else if (clr) m_f[i] = 0;
            end
            if (mode_a) begin if (ra) m_gra = c0; end
            else if (bus_wr && bus_addr == 4) m_gra = (m_gra & 16'hFF00) | bus_wdata;
            else if (bus_wr && bus_addr == 5) m_gra = (m_gra & 16'h00FF) | (bus_wdata << 8);
            if (mode_b) begin if (rb) m_grb = c0; end
            else if (bus_wr && bus_addr == 6) m_grb = (m_grb & 16'hFF00) | bus_wdata;
            else if (bus_wr && bus_addr == 7) m_grb = (m_grb & 16'h00FF) | (bus_wdata << 8);
            if (bus_wr && bus_addr == 2)      m_cnt = (c0 & 16'hFF00) | bus_wdata;
            else if (bus_wr && bus_addr == 3) m_cnt = (c0 & 16'h00FF) | (bus_wdata << 8);
            else if (cnt_en) m_cnt = (cnt_down ? c0 - 1 : c0 + 1) & 16'hFFFF;
            ma[2] = ma[1]; ma[1] = ma[0]; ma[0] = cap_a;
            mb[2] = mb[1]; mb[1] = mb[0]; mb[0] = cap_b;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask
    task automatic rd_stat();
        @(negedge clk); bus_addr = 0; bus_rd = 1;
        @(negedge clk); bus_rd = 0;
    endtask
    task automatic look(input logic [2:0] a);
        @(negedge clk); bus_addr = a; #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R2 status after reset", bus_rdata, 8'hF8);
        look(2); chk("R2 counter low after reset", bus_rdata, 8'h00);
        look(5); chk("R2 reg A high after reset", bus_rdata, 8'h00);
        look(1); chk("R1 reserved address", bus_rdata, 8'h00);

        // R12 hold and load
        idle(3); look(2); chk("R12 counter holds", bus_rdata, 8'h00);
        wr(2, 8'hFE); wr(3, 8'hFF);
        look(2); chk("R12 counter low loaded", bus_rdata, 8'hFE);
        look(3); chk("R12 counter high loaded", bus_rdata, 8'hFF);

        // R3 wrap up: FFFE -> FFFF -> 0000
        @(negedge clk); cnt_en = 1;
        idle(2); cnt_en = 0;
        look(0); chk("R3 wrap flag after up wrap", bus_rdata & 8'h04, 8'h04);
        look(2); chk("R3 counter low after wrap", bus_rdata, 8'h00);

        // R8 zero write without read
        wr(0, 8'h00);
        look(0); chk("R8 unarmed zero write ignored", bus_rdata, 8'hFC & m_read(0) | 8'h04);
        chk("R8 wrap still set", bus_rdata & 8'h04, 8'h04);

        // R7 one write after arming, then R9 clear
        rd_stat();
        wr(0, 8'hFF);
        look(0); chk("R7 one write keeps flag", bus_rdata & 8'hFC, 8'hFC);
        wr(0, 8'hFB);
        look(0); chk("R9 armed zero write clears", bus_rdata & 8'h04, 8'h00);

        // R9 arm used up: re-set wrap, zero write without reread
        wr(2, 8'hFF); wr(3, 8'hFF);
        @(negedge clk); cnt_en = 1; @(negedge clk); cnt_en = 0;
        wr(0, 8'h00);
        look(0); chk("R9 arm consumed, flag stays", bus_rdata & 8'h04, 8'h04);

        // R10 set beats clear in same cycle
        rd_stat();
        wr(2, 8'hFF); wr(3, 8'hFF);
        @(negedge clk); cnt_en = 1; bus_addr = 0; bus_wdata = 8'h00; bus_wr = 1;
        @(negedge clk); cnt_en = 0; bus_wr = 0;
        look(0); chk("R10 set wins over clear", bus_rdata & 8'h04, 8'h04);
        wr(0, 8'h00);
        look(0); chk("R10 arm used by lost clear", bus_rdata & 8'h04, 8'h04);

        // R4 wrap down
        rd_stat(); wr(0, 8'hFB);
        look(0); chk("R4 precondition cleared", bus_rdata & 8'h04, 8'h00);
        wr(2, 8'h00); wr(3, 8'h00);
        @(negedge clk); cnt_down = 1; cnt_en = 1; @(negedge clk); cnt_en = 0;
        look(0); chk("R4 wrap flag after down wrap", bus_rdata & 8'h04, 8'h04);
        look(2); chk("R4 counter low after down wrap", bus_rdata, 8'hFF);
        cnt_down = 0;

        // R5 compare on A
        wr(2, 8'h08); wr(3, 8'h00);
        @(negedge clk); mode_a = 0;
        wr(4, 8'h10); wr(5, 8'h00);
        look(0); chk("R5 no match yet", bus_rdata & 8'h01, 8'h00);
        @(negedge clk); cnt_en = 1;
        idle(10); cnt_en = 0;
        look(0); chk("R5 compare flag set", bus_rdata & 8'h01, 8'h01);

        // R6 capture on B
        @(negedge clk); cnt_en = 1; cap_b = 1;
        idle(2); cap_b = 0;
        idle(2); cnt_en = 0;
        look(0); chk("R6 capture flag set", bus_rdata & 8'h02, 8'h02);
        look(6); chk("R6 captured value", bus_rdata, m_read(6));
        saved = bus_rdata;

        // R11 write blocked in capture mode, accepted in compare mode
        wr(6, 8'h55);
        look(6); chk("R11 capture mode ignores write", bus_rdata, saved);
        @(negedge clk); mode_b = 0;
        wr(6, 8'h55);
        look(6); chk("R11 compare mode accepts write", bus_rdata, 8'h55);

        idle(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule